// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits between a set of interrupt request lines and a processor core. It holds one enable bit per request line and a global interrupt-enable flag. In each cycle where the core says it can accept an interrupt, the block picks the winning request. A request can win only when its own enable bit and the global flag are both set. Among such requests, the one with the lowest index wins. The block then presents that source's program-memory vector address together with a one-cycle take strobe.

On the same edge, the block sends a one-hot acknowledge to the winning source and clears the global flag, so no second interrupt can nest. A return-from-interrupt indication sets the flag again. The status register and the return address are handled elsewhere. The only status state this block changes is the global flag.

A reset request cannot be masked. It beats every interrupt, whatever the state of the global flag or the core-ready signal. It clears all enable bits and the global flag, and it produces vector address 0. Source bit i has its vector at address VEC_BASE + VEC_STEP*(i+1); with the defaults this is 2*(i+1).

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, `take`, `irq_ack`, `vec_addr`, `en_mask` and `gie` are all zero.
- R2: `en_mask` shows `en_wdata` one cycle after a cycle with `en_wr` high. `gie` shows `gie_wdata` one cycle after a cycle with `gie_wr` high, provided no interrupt or reset is taken in that cycle.
- R3: If `core_ready`, `gie` and at least one `irq_req[i] & en_mask[i]` are all 1 in a cycle, `take` is 1 in the next cycle. It stays high for exactly that one cycle.
- R4: When several enabled requests are pending, the lowest bit index wins. `vec_addr` then equals 2*(i+1) for winning bit i.
- R5: `irq_ack` is one-hot, with only bit i of the winner set, in the same cycle as `take`. It is all zero whenever `take` is 0.
- R6: A request whose `en_mask` bit is 0 is never taken. No interrupt is taken while `gie` is 0 or `core_ready` is 0.
- R7: Taking an interrupt leaves `gie` at 0 in the cycle where `take` is high, even if `reti` or `gie_wr` was high in the deciding cycle. A `reti` pulse sets `gie` to 1 one cycle later.
- R8: A cycle with `rst_req` high gives, in the next cycle, `take`=1, `vec_addr`=0, `irq_ack`=0, `en_mask`=0 and `gie`=0. This holds whatever the values of `gie`, `core_ready` and the pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| rst_req | input | 1 | Non-maskable reset request, highest priority |
| irq_req | input | NUM_SRC | Interrupt request lines; bit 0 has the highest priority |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_SRC | New enable bits |
| gie_wr | input | 1 | Write strobe for the global flag |
| gie_wdata | input | 1 | New global flag value |
| reti | input | 1 | Return-from-interrupt indication; sets the global flag |
| core_ready | input | 1 | Core can accept an interrupt this cycle |
| take | output | 1 | One-cycle strobe: a vector is being issued |
| vec_addr | output | PC_W | Program-memory vector address of the taken source |
| irq_ack | output | NUM_SRC | One-hot acknowledge to the chosen source |
| en_mask | output | NUM_SRC | Current enable bits |
| gie | output | 1 | Current global interrupt-enable flag |

## Verification
Every result is registered, so `take`, `vec_addr`, `irq_ack`, `en_mask` and `gie` all change on the first rising edge after the cycle that decided them. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which places each check exactly one register stage after its stimulus. It then reads once more, one cycle later, to confirm that the strobe has dropped. The `gie` restore after `reti` and the effects of a reset request are sampled with the same one-cycle spacing. In those checks, the bench holds the other inputs idle so that a single input decides each result.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   // next-state selector for the global interrupt-enable flag
   typedef enum logic [1:0] {
      GIE_HOLD = 2'd0,
      GIE_CLR  = 2'd1,
      GIE_LOAD = 2'd2,
      GIE_SET  = 2'd3
   } gie_op_e;

endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
   parameter int NUM_SRC = 20,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] grant
);

   // isolate the lowest set bit: that is the one-hot winner
   assign grant = pend & (~pend + NUM_SRC'(1));
   assign any   = |pend;

   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/ivc_vec_gen.sv
module ivc_vec_gen #(
   parameter int NUM_SRC  = 20,
   parameter int PC_W     = 16,
   parameter int VEC_BASE = 0,
   parameter int VEC_STEP = 2,
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam bit STEP_P2 = (VEC_STEP > 0) && ((VEC_STEP & (VEC_STEP - 1)) == 0),
   localparam int STEP_SH = (VEC_STEP > 1) ? $clog2(VEC_STEP) : 0
) (
   input  logic             is_rst,
   input  logic [IDX_W-1:0] idx,
   output logic [PC_W-1:0]  addr
);

   logic [PC_W-1:0] slot;
   logic [PC_W-1:0] offs;

   // slot 0 is reserved for reset; source bit i uses slot i+1
   assign slot = PC_W'(idx) + PC_W'(1);

   if (STEP_P2) begin : g_shift
      assign offs = slot << STEP_SH;
   end else begin : g_mult
      assign offs = PC_W'(slot * PC_W'(VEC_STEP));
   end

   assign addr = is_rst ? PC_W'(VEC_BASE) : PC_W'(VEC_BASE) + offs;

endmodule

// File: rtl/ivc_flag_ctrl.sv
module ivc_flag_ctrl
   import ivc_pkg::*;
#(
   parameter int NUM_SRC = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req,
   input  logic               irq_taken,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic               gie_wr,
   input  logic               gie_wdata,
   input  logic               reti,
   output logic [NUM_SRC-1:0] en_mask,
   output logic               gie
);

   gie_op_e gie_op;

   // precedence: reset, then entry, then explicit write, then return
   always_comb begin
      if (rst_req || irq_taken) gie_op = GIE_CLR;
      else if (gie_wr)          gie_op = GIE_LOAD;
      else if (reti)            gie_op = GIE_SET;
      else                      gie_op = GIE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask <= '0;
      end else if (rst_req) begin
         en_mask <= '0;
      end else if (en_wr) begin
         en_mask <= en_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie <= 1'b0;
      end else begin
         unique case (gie_op)
            GIE_CLR:  gie <= 1'b0;
            GIE_LOAD: gie <= gie_wdata;
            GIE_SET:  gie <= 1'b1;
            default:  gie <= gie;
         endcase
      end
   end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int NUM_SRC  = 20,
   parameter int PC_W     = 16,
   parameter int VEC_BASE = 0,
   parameter int VEC_STEP = 2,
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam longint TOP_ADDR = longint'(VEC_BASE) + longint'(NUM_SRC) * longint'(VEC_STEP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic               gie_wr,
   input  logic               gie_wdata,
   input  logic               reti,
   input  logic               core_ready,
   output logic               take,
   output logic [PC_W-1:0]    vec_addr,
   output logic [NUM_SRC-1:0] irq_ack,
   output logic [NUM_SRC-1:0] en_mask,
   output logic               gie
);

   if (NUM_SRC < 1) begin : g_bad_nsrc
      $error("irq_vector_ctrl: NUM_SRC must be at least 1");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irq_vector_ctrl: VEC_STEP must be at least 1");
   end
   if (PC_W < 2 || PC_W > 32 || TOP_ADDR >= (longint'(1) << PC_W)) begin : g_bad_pcw
      $error("irq_vector_ctrl: vector table does not fit in PC_W bits");
   end

   logic [NUM_SRC-1:0] pend;
   logic               pend_any;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_SRC-1:0] win_oh;
   logic [PC_W-1:0]    win_addr;
   logic               irq_go;
   logic               take_go;

   assign pend    = irq_req & en_mask;
   assign irq_go  = core_ready & gie & pend_any & ~rst_req;
   assign take_go = rst_req | irq_go;

   ivc_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
      .pend  (pend),
      .any   (pend_any),
      .idx   (win_idx),
      .grant (win_oh)
   );

   ivc_vec_gen #(
      .NUM_SRC  (NUM_SRC),
      .PC_W     (PC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_vec (
      .is_rst (rst_req),
      .idx    (win_idx),
      .addr   (win_addr)
   );

   ivc_flag_ctrl #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_req   (rst_req),
      .irq_taken (irq_go),
      .en_wr     (en_wr),
      .en_wdata  (en_wdata),
      .gie_wr    (gie_wr),
      .gie_wdata (gie_wdata),
      .reti      (reti),
      .en_mask   (en_mask),
      .gie       (gie)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take     <= 1'b0;
         vec_addr <= '0;
         irq_ack  <= '0;
      end else begin
         take    <= take_go;
         irq_ack <= irq_go ? win_oh : '0;
         if (take_go) vec_addr <= win_addr;
      end
   end

endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
   parameter int NUM_SRC = 20,
   parameter int PC_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_req,
   input logic [NUM_SRC-1:0] irq_req,
   input logic               core_ready,
   input logic               take,
   input logic [PC_W-1:0]    vec_addr,
   input logic [NUM_SRC-1:0] irq_ack,
   input logic [NUM_SRC-1:0] en_mask,
   input logic               gie
);

   a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   a_r5_ack_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> take);

   a_r6_ack_was_enabled_req: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> ((irq_ack & $past(irq_req & en_mask)) != '0));

   a_r6_take_needs_gie_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !$past(rst_req)) |-> ($past(gie) && $past(core_ready)));

   a_r7_take_leaves_gie_clear: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !gie);

   a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !$past(rst_req)) |=> (!take || $past(rst_req, 1)));

   a_r8_reset_req_effect: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_req) |-> (take && vec_addr == '0 && irq_ack == '0 && en_mask == '0 && !gie));

endmodule

bind irq_vector_ctrl ivc_chk #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_ivc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_req    (rst_req),
   .irq_req    (irq_req),
   .core_ready (core_ready),
   .take       (take),
   .vec_addr   (vec_addr),
   .irq_ack    (irq_ack),
   .en_mask    (en_mask),
   .gie        (gie)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

   localparam int N  = 20;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rst_req = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          en_wr = 1'b0;
   logic [N-1:0]  en_wdata = '0;
   logic          gie_wr = 1'b0;
   logic          gie_wdata = 1'b0;
   logic          reti = 1'b0;
   logic          core_ready = 1'b0;
   logic          take;
   logic [PW-1:0] vec_addr;
   logic [N-1:0]  irq_ack;
   logic [N-1:0]  en_mask;
   logic          gie;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_vector_ctrl #(.NUM_SRC(N), .PC_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_req(irq_req),
      .en_wr(en_wr), .en_wdata(en_wdata), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
      .reti(reti), .core_ready(core_ready), .take(take), .vec_addr(vec_addr),
      .irq_ack(irq_ack), .en_mask(en_mask), .gie(gie)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_en(input logic [N-1:0] m);
      en_wr = 1'b1; en_wdata = m;
      step();
      en_wr = 1'b0;
   endtask

   task automatic write_gie(input logic v);
      gie_wr = 1'b1; gie_wdata = v;
      step();
      gie_wr = 1'b0;
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   // present a request pattern for one cycle and compare the registered result
   task automatic attempt(input logic [N-1:0] req, input logic rdy, input string tag);
      int w;
      logic exp_take;
      w = lowest(req & en_mask);
      exp_take = rdy && gie && (w >= 0);
      irq_req = req; core_ready = rdy;
      step();
      irq_req = '0; core_ready = 1'b0;
      chk(take == exp_take, tag, take, exp_take);
      if (exp_take) begin
         chk(vec_addr == PW'(2 * (w + 1)), "R4 vector", vec_addr, 2 * (w + 1));
         chk(irq_ack == (N'(1) << w), "R5 ack", irq_ack, N'(1) << w);
         chk(gie == 1'b0, "R7 gie cleared", gie, 0);
         step();
         chk(take == 1'b0 && irq_ack == '0, "R3 single-cycle strobe", take, 0);
         reti = 1'b1;
         step();
         reti = 1'b0;
         chk(gie == 1'b1, "R7 reti restores gie", gie, 1);
      end else begin
         chk(irq_ack == '0, "R5 no ack without take", irq_ack, 0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      // R1: reset state
      chk(take == 0 && irq_ack == '0 && vec_addr == '0 && en_mask == '0 && gie == 0,
          "R1 reset state", {take, gie}, 0);
      rst_n = 1'b1;
      step();

      // R2: register writes
      write_en(N'(20'hA5A5A));
      chk(en_mask == N'(20'hA5A5A), "R2 enable write", en_mask, 20'hA5A5A);
      write_gie(1'b1);
      chk(gie == 1'b1, "R2 gie write", gie, 1);
      write_gie(1'b0);
      chk(gie == 1'b0, "R2 gie clear write", gie, 0);

      // R6: gie low blocks everything
      write_en('1);
      attempt('1, 1'b1, "R6 gie low blocks");
      write_gie(1'b1);
      // R6: core not ready blocks
      attempt('1, 1'b0, "R6 core not ready blocks");

      // R3/R4: each source alone
      for (int k = 0; k < N; k++) attempt(N'(1) << k, 1'b1, "R3 single source taken");

      // R4: every pair, lower index must win
      for (int i = 0; i < N; i++)
         for (int j = i + 1; j < N; j++)
            attempt((N'(1) << i) | (N'(1) << j), 1'b1, "R4 pair priority");

      // R6: masked sources are skipped or blocked
      for (int k = 0; k < N; k++) begin
         write_en(~(N'(1) << k));
         attempt(N'(1) << k, 1'b1, "R6 disabled source ignored");
         attempt((N'(1) << k) | (N'(1) << (N - 1 - k)), 1'b1, "R6 masked pair");
      end
      write_en(N'(20'h0F0F0));
      attempt(N'(20'hFFFFF), 1'b1, "R6 mask selects winner");

      // R7: take overrides reti and gie write in the same cycle
      write_en('1);
      irq_req = N'(1) << 5; core_ready = 1'b1; reti = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b1;
      step();
      irq_req = '0; core_ready = 1'b0; reti = 1'b0; gie_wr = 1'b0;
      chk(take == 1'b1 && gie == 1'b0, "R7 entry beats reti", gie, 0);
      step();
      write_gie(1'b1);

      // R8: reset request with pending work
      irq_req = '1; core_ready = 1'b1; rst_req = 1'b1;
      step();
      rst_req = 1'b0; irq_req = '0; core_ready = 1'b0;
      chk(take == 1'b1, "R8 reset take", take, 1);
      chk(vec_addr == '0, "R8 reset vector", vec_addr, 0);
      chk(irq_ack == '0, "R8 no ack", irq_ack, 0);
      chk(en_mask == '0 && gie == 1'b0, "R8 state cleared", en_mask, 0);
      // R8: not maskable even with gie low and core not ready
      rst_req = 1'b1;
      step();
      rst_req = 1'b0;
      chk(take == 1'b1 && vec_addr == '0, "R8 reset ignores gie", take, 1);
      step();
      chk(take == 1'b0, "R3 strobe drops after reset", take, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule